// File: doc/BRIEF.md
# Memory Write Protection Controller

This block decides whether writes to a 256-byte serial-bus memory are allowed. It sits beside an I2C byte engine that has already decoded the bus into events: START, STOP, a completed received byte, and the falling clock edge that closes each acknowledge slot. For every byte the block has an opinion on, it answers with an acknowledge verdict one clock later. The byte engine drives that verdict onto the bus.

The block holds two software protection flags. The permanent flag can be set but never cleared. The reversible flag can be set and cleared, but only while a high-voltage detector on the lowest address strap stays asserted for the whole transaction. Commands for these flags use their own slave-address preamble. A flag query returns no data: the flag's state appears in the acknowledge bit alone. A hardware write-protect pin is sampled once per write transaction, at the close of the acknowledge slot that follows the address byte. When it is high, that write is refused. Flag changes take effect only at a STOP that ends a fully accepted command. Each change is reported by a one-cycle strobe.

Top module: `wp_ctrl`

## Requirements
- R1: After reset both flags are clear, `ack_vld` is low and no update strobe is high.
- R2: A slave-address byte with bits [7:4] = 1010 and bits [3:1] equal to `strap` is acknowledged, as is the address byte of a write that follows it. Any slave-address byte that no rule accepts gives `ack_vld` with `ack_ok` low, and the rest of that transaction is ignored. Bytes received after a read address (bit 0 = 1) produce no verdict.
- R3: During a memory write with WP low, each data byte is acknowledged. The exception is a `wr_addr` below 0x80 while either flag is set: that byte is refused. Addresses 0x80 and above stay writable.
- R4: `wp_pin` is sampled on the first `ack_end` after the address byte of a write. If it is high then, every data byte of that transaction is refused. WP changes at other moments have no effect.
- R5: A slave-address byte with bits [7:4] = 0110 and bit 0 = 0, with no high-voltage qualification, is a set-permanent command. Its slave address, dummy address and dummy data bytes are acknowledged, and the following STOP pulses `set_perm_stb` and sets `perm_flag`.
- R6: A query (preamble 0110, bit 0 = 1) produces exactly one verdict, with `ack_ok` equal to the inverse of the queried flag. With high-voltage qualification and select bits 001 or 011, the reversible flag is queried. Without qualification, the permanent flag is queried.
- R7: With high-voltage qualification, select bits [3:1] = 001 and bit 0 = 0 set the reversible flag, and select bits 011 clear it. In each case the STOP pulses `set_rev_stb` or `clr_rev_stb` respectively.
- R8: The high-voltage qualification holds only if `hv_a0` is high at START and stays high through STOP. A command whose qualification was missing at START is decoded as a permanent-flag command. A reversible write command whose qualification drops before STOP sets the permanent flag instead.
- R9: With high-voltage qualification, a protection slave address whose select bits are neither 001 nor 011 is refused.
- R10: Once `perm_flag` is set, it never clears, and every protection write command is refused at its slave address.
- R11: If WP is high at the sampling moment of a protection write, its data byte is refused and the STOP changes no flag.
- R12: A START before the STOP of a protection command cancels it, so no flag changes. At most one strobe is high in any cycle.
- R13: `ack_vld` is high exactly in the cycle after an `rx_vld` that the block judges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | One-cycle pulse on START or repeated START |
| bus_stop | input | 1 | One-cycle pulse on STOP |
| rx_vld | input | 1 | One-cycle pulse: a byte from the master is complete |
| rx_byte | input | 8 | The completed byte |
| ack_end | input | 1 | Pulse on the SCL falling edge closing an acknowledge slot |
| strap | input | 3 | Logic levels of the three address straps |
| hv_a0 | input | 1 | High-voltage detector on the lowest strap |
| wp_pin | input | 1 | Hardware write-protect level |
| wr_addr | input | 8 | Memory location the next data byte would write |
| ack_vld | output | 1 | Verdict valid for the byte just received |
| ack_ok | output | 1 | 1 = acknowledge, 0 = refuse |
| perm_flag | output | 1 | Permanent protection flag |
| rev_flag | output | 1 | Reversible protection flag |
| set_perm_stb | output | 1 | Permanent flag was set at this STOP |
| set_rev_stb | output | 1 | Reversible flag was set at this STOP |
| clr_rev_stb | output | 1 | Reversible flag was cleared at this STOP |

## Verification
The bench targets the points where a plausible mistake hides. One is the high-voltage qualifier applied after START: a design that only looks at the level when the slave address arrives would answer a reversible query instead of a permanent one. Another is a qualifier dropped before STOP: a design that forgets the conversion leaves the permanent flag clear. WP is raised before the sampling edge and lowered after it, and the other way round, which exposes a design that samples on the data byte itself. The bench also pairs boundary addresses 0x7F/0x80 with a set flag, cancels a complete command with a repeated START, and sends set and clear commands after the permanent flag is set. Designs that mishandle these either acknowledge a refused byte or move a flag.

// File: rtl/wp_pkg.sv
package wp_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SLV,
      ST_MWADDR,
      ST_MDATA,
      ST_MRD,
      ST_PADDR,
      ST_PDATA,
      ST_PDONE,
      ST_SKIP
   } wp_state_e;

   typedef enum logic [1:0] {
      CMD_NONE,
      CMD_PSET,
      CMD_RSET,
      CMD_RCLR
   } wp_cmd_e;

   typedef struct packed {
      logic    mem_hit;
      logic    prot_hit;
      logic    bad_sel;
      logic    query_rev;
      logic    rd;
      wp_cmd_e cmd;
   } slv_dec_t;

endpackage

// File: rtl/wp_slv_decode.sv
module wp_slv_decode
   import wp_pkg::*;
#(
   parameter int         BYTE_W   = 8,
   parameter logic [3:0] MEM_PRE  = 4'b1010,
   parameter logic [3:0] PROT_PRE = 4'b0110,
   parameter logic [2:0] SEL_RSET = 3'b001,
   parameter logic [2:0] SEL_RCLR = 3'b011
) (
   input  logic [BYTE_W-1:0] slv_byte,
   input  logic [2:0]        strap,
   input  logic              hv_live,
   output slv_dec_t          dec
);
   localparam int PRE_LO = BYTE_W - 4;

   logic [3:0] pre;
   logic [2:0] sel;
   logic       rev_sel;

   always_comb begin
      pre     = slv_byte[BYTE_W-1:PRE_LO];
      sel     = slv_byte[3:1];
      rev_sel = (sel == SEL_RSET) || (sel == SEL_RCLR);

      dec.rd        = slv_byte[0];
      dec.mem_hit   = (pre == MEM_PRE) && (sel == strap);
      dec.prot_hit  = (pre == PROT_PRE);
      dec.bad_sel   = dec.prot_hit && hv_live && !rev_sel;
      dec.query_rev = dec.prot_hit && hv_live && rev_sel && dec.rd;
      dec.cmd       = CMD_NONE;
      if (dec.prot_hit && !dec.rd) begin
         if (!hv_live)
            dec.cmd = CMD_PSET;
         else if (sel == SEL_RSET)
            dec.cmd = CMD_RSET;
         else if (sel == SEL_RCLR)
            dec.cmd = CMD_RCLR;
      end
   end
endmodule

// File: rtl/wp_hv_track.sv
module wp_hv_track (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_start,
   input  logic hv_a0,
   output logic hv_live
);
   logic hv_held;

   always_ff @(posedge clk) begin
      if (!rst_n)
         hv_held <= 1'b0;
      else if (bus_start)
         hv_held <= hv_a0;
      else if (!hv_a0)
         hv_held <= 1'b0;
   end

   assign hv_live = hv_held && hv_a0;
endmodule

// File: rtl/wp_flags.sv
module wp_flags
   import wp_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    exec,
   input  wp_cmd_e cmd,
   output logic    perm_flag,
   output logic    rev_flag,
   output logic    set_perm_stb,
   output logic    set_rev_stb,
   output logic    clr_rev_stb
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         perm_flag    <= 1'b0;
         rev_flag     <= 1'b0;
         set_perm_stb <= 1'b0;
         set_rev_stb  <= 1'b0;
         clr_rev_stb  <= 1'b0;
      end else begin
         set_perm_stb <= 1'b0;
         set_rev_stb  <= 1'b0;
         clr_rev_stb  <= 1'b0;
         if (exec) begin
            unique case (cmd)
               CMD_PSET: begin perm_flag <= 1'b1; set_perm_stb <= 1'b1; end
               CMD_RSET: begin rev_flag  <= 1'b1; set_rev_stb  <= 1'b1; end
               CMD_RCLR: begin rev_flag  <= 1'b0; clr_rev_stb  <= 1'b1; end
               default:  ;
            endcase
         end
      end
   end
endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
   import wp_pkg::*;
#(
   parameter int         MEM_DEPTH  = 256,
   parameter int         PROT_LIMIT = 128,
   parameter logic [3:0] MEM_PRE    = 4'b1010,
   parameter logic [3:0] PROT_PRE   = 4'b0110,
   parameter logic [2:0] SEL_RSET   = 3'b001,
   parameter logic [2:0] SEL_RCLR   = 3'b011,
   localparam int        AW         = $clog2(MEM_DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_start,
   input  logic          bus_stop,
   input  logic          rx_vld,
   input  logic [7:0]    rx_byte,
   input  logic          ack_end,
   input  logic [2:0]    strap,
   input  logic          hv_a0,
   input  logic          wp_pin,
   input  logic [AW-1:0] wr_addr,
   output logic          ack_vld,
   output logic          ack_ok,
   output logic          perm_flag,
   output logic          rev_flag,
   output logic          set_perm_stb,
   output logic          set_rev_stb,
   output logic          clr_rev_stb
);
   localparam bit LIM_IS_HALF = (PROT_LIMIT * 2 == MEM_DEPTH);

   if (PROT_LIMIT > MEM_DEPTH || PROT_LIMIT < 1) begin : g_bad_limit
      $error("wp_ctrl: PROT_LIMIT must lie in 1..MEM_DEPTH");
   end
   if (MEM_DEPTH != (1 << AW)) begin : g_bad_depth
      $error("wp_ctrl: MEM_DEPTH must be a power of two");
   end
   if (MEM_PRE == PROT_PRE) begin : g_bad_pre
      $error("wp_ctrl: preambles must differ");
   end

   wp_state_e state;
   wp_cmd_e   cmd_q;
   wp_cmd_e   cmd_eff;
   logic      wp_q;
   logic      wp_taken;
   logic      hv_live;
   logic      low_zone;
   logic      exec;
   slv_dec_t  dec;

   // Protected-region compare: MSB test when the limit is half the array.
   if (LIM_IS_HALF) begin : g_half
      assign low_zone = !wr_addr[AW-1];
   end else begin : g_cmp
      assign low_zone = ({1'b0, wr_addr} < (AW+1)'(PROT_LIMIT));
   end

   wp_hv_track u_hv (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_start (bus_start),
      .hv_a0     (hv_a0),
      .hv_live   (hv_live)
   );

   wp_slv_decode #(
      .BYTE_W   (8),
      .MEM_PRE  (MEM_PRE),
      .PROT_PRE (PROT_PRE),
      .SEL_RSET (SEL_RSET),
      .SEL_RCLR (SEL_RCLR)
   ) u_dec (
      .slv_byte (rx_byte),
      .strap    (strap),
      .hv_live  (hv_live),
      .dec      (dec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cmd_q    <= CMD_NONE;
         wp_q     <= 1'b0;
         wp_taken <= 1'b0;
         ack_vld  <= 1'b0;
         ack_ok   <= 1'b0;
      end else begin
         ack_vld <= 1'b0;
         if (bus_start) begin
            state    <= ST_SLV;
            cmd_q    <= CMD_NONE;
            wp_q     <= 1'b0;
            wp_taken <= 1'b0;
         end else if (bus_stop) begin
            state <= ST_IDLE;
         end else begin
            if (ack_end && !wp_taken && (state == ST_MDATA || state == ST_PDATA)) begin
               wp_q     <= wp_pin;
               wp_taken <= 1'b1;
            end
            if (rx_vld) begin
               unique case (state)
                  ST_SLV: begin
                     ack_vld <= 1'b1;
                     if (dec.mem_hit) begin
                        ack_ok <= 1'b1;
                        state  <= dec.rd ? ST_MRD : ST_MWADDR;
                     end else if (dec.bad_sel) begin
                        ack_ok <= 1'b0;
                        state  <= ST_SKIP;
                     end else if (dec.prot_hit && dec.rd) begin
                        ack_ok <= dec.query_rev ? !rev_flag : !perm_flag;
                        state  <= ST_SKIP;
                     end else if (dec.prot_hit) begin
                        ack_ok <= !perm_flag;
                        cmd_q  <= dec.cmd;
                        state  <= perm_flag ? ST_SKIP : ST_PADDR;
                     end else begin
                        ack_ok <= 1'b0;
                        state  <= ST_SKIP;
                     end
                  end
                  ST_MWADDR: begin
                     ack_vld <= 1'b1;
                     ack_ok  <= 1'b1;
                     state   <= ST_MDATA;
                  end
                  ST_MDATA: begin
                     ack_vld <= 1'b1;
                     ack_ok  <= !wp_q && !(low_zone && (perm_flag || rev_flag));
                  end
                  ST_PADDR: begin
                     ack_vld <= 1'b1;
                     ack_ok  <= 1'b1;
                     state   <= ST_PDATA;
                  end
                  ST_PDATA: begin
                     ack_vld <= 1'b1;
                     ack_ok  <= !wp_q;
                     state   <= wp_q ? ST_SKIP : ST_PDONE;
                  end
                  ST_PDONE: begin
                     ack_vld <= 1'b1;
                     ack_ok  <= 1'b0;
                     state   <= ST_SKIP;
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   // A reversible command that lost its qualifier before STOP becomes a permanent set.
   always_comb begin
      cmd_eff = cmd_q;
      if ((cmd_q == CMD_RSET || cmd_q == CMD_RCLR) && !hv_live)
         cmd_eff = CMD_PSET;
   end

   assign exec = bus_stop && !bus_start && (state == ST_PDONE);

   wp_flags u_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .exec         (exec),
      .cmd          (cmd_eff),
      .perm_flag    (perm_flag),
      .rev_flag     (rev_flag),
      .set_perm_stb (set_perm_stb),
      .set_rev_stb  (set_rev_stb),
      .clr_rev_stb  (clr_rev_stb)
   );
endmodule

// File: rtl/wp_ctrl_chk.sv
module wp_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic bus_stop,
   input logic rx_vld,
   input logic ack_vld,
   input logic perm_flag,
   input logic rev_flag,
   input logic set_perm_stb,
   input logic set_rev_stb,
   input logic clr_rev_stb
);
   // R13
   verdict_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vld |-> $past(rx_vld));

   // R10
   perm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(perm_flag));

   // R10
   no_rev_set_after_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_rev_stb || clr_rev_stb) |-> !$past(perm_flag));

   // R12
   update_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_perm_stb || set_rev_stb || clr_rev_stb) |-> $past(bus_stop));

   // R12
   single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({set_perm_stb, set_rev_stb, clr_rev_stb}));

   // R7
   rev_rise_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rev_flag) |-> set_rev_stb);

   // R7
   rev_fall_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rev_flag) |-> clr_rev_stb);

   // R5
   perm_rise_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(perm_flag) |-> set_perm_stb);
endmodule

bind wp_ctrl wp_ctrl_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_stop     (bus_stop),
   .rx_vld       (rx_vld),
   .ack_vld      (ack_vld),
   .perm_flag    (perm_flag),
   .rev_flag     (rev_flag),
   .set_perm_stb (set_perm_stb),
   .set_rev_stb  (set_rev_stb),
   .clr_rev_stb  (clr_rev_stb)
);

// File: tb/sim_wp_ctrl.sv
`timescale 1ns/1ps
module sim_wp_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_start = 1'b0, bus_stop = 1'b0, rx_vld = 1'b0, ack_end = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic [2:0] strap = 3'b101;
   logic       hv_a0 = 1'b0, wp_pin = 1'b0;
   logic [7:0] wr_addr = 8'h00;
   logic       ack_vld, ack_ok, perm_flag, rev_flag;
   logic       set_perm_stb, set_rev_stb, clr_rev_stb;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   bit  exp_q[$];
   string tag_q[$];

   always #4 clk = ~clk;

   wp_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
      .rx_vld(rx_vld), .rx_byte(rx_byte), .ack_end(ack_end), .strap(strap),
      .hv_a0(hv_a0), .wp_pin(wp_pin), .wr_addr(wr_addr),
      .ack_vld(ack_vld), .ack_ok(ack_ok), .perm_flag(perm_flag), .rev_flag(rev_flag),
      .set_perm_stb(set_perm_stb), .set_rev_stb(set_rev_stb), .clr_rev_stb(clr_rev_stb)
   );

   // Monitor: pops one expected verdict per ack_vld (R13 timing).
   always @(negedge clk) begin
      if (rst_n && ack_vld) begin
         n_vec++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R13 unexpected verdict: actual ack_vld=1 expected 0");
         end else begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (ack_ok !== e) begin
               n_bad++;
               $display("FAIL %s ack_ok actual=%0b expected=%0b", t, ack_ok, e);
            end
         end
      end
   end

   task automatic chk(input logic act, input logic exp, input string tag);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic t_start();
      @(negedge clk); bus_start = 1'b1;
      @(negedge clk); bus_start = 1'b0;
   endtask

   // Driver: pushes the expected verdict, then presents the byte.
   task automatic t_byte(input logic [7:0] b, input bit judged, input bit e, input string tag);
      @(negedge clk);
      if (judged) begin exp_q.push_back(e); tag_q.push_back(tag); end
      rx_byte = b; rx_vld = 1'b1;
      @(negedge clk); rx_vld = 1'b0;
      #1;
      if (exp_q.size() != 0) begin
         void'(exp_q.pop_front()); void'(tag_q.pop_front());
         n_vec++; n_bad++;
         $display("FAIL %s missing verdict: actual ack_vld=0 expected 1", tag);
      end
   endtask

   task automatic t_ackend();
      @(negedge clk); ack_end = 1'b1;
      @(negedge clk); ack_end = 1'b0;
   endtask

   task automatic t_stop(input logic ep, input logic es, input logic ec, input string tag);
      @(negedge clk); bus_stop = 1'b1;
      @(negedge clk); bus_stop = 1'b0;
      chk(set_perm_stb, ep, {tag, " set_perm_stb"});
      chk(set_rev_stb,  es, {tag, " set_rev_stb"});
      chk(clr_rev_stb,  ec, {tag, " clr_rev_stb"});
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(perm_flag, 1'b0, "R1 perm_flag");
      chk(rev_flag,  1'b0, "R1 rev_flag");
      chk(ack_vld,   1'b0, "R1 ack_vld");
      chk(set_perm_stb | set_rev_stb | clr_rev_stb, 1'b0, "R1 strobes");

      // R2/R3 plain memory write
      t_start();
      t_byte(8'hAA, 1, 1, "R2 mem slave addr");
      t_byte(8'h10, 1, 1, "R2 word addr");
      t_ackend();
      wr_addr = 8'h10; t_byte(8'h55, 1, 1, "R3 data unprotected");
      wr_addr = 8'h11; t_byte(8'h66, 1, 1, "R3 second data");
      t_stop(0, 0, 0, "R3");

      // R2 strap mismatch, then rest ignored
      t_start();
      t_byte(8'hA2, 1, 0, "R2 strap mismatch");
      t_byte(8'h00, 0, 0, "R2 ignored");
      t_stop(0, 0, 0, "R2");

      // R2 read: following bytes get no verdict
      t_start();
      t_byte(8'hAB, 1, 1, "R2 mem read addr");
      t_byte(8'h12, 0, 0, "R2 read phase");
      t_stop(0, 0, 0, "R2 read");

      // R4 WP high at the strobe, low afterwards
      t_start();
      t_byte(8'hAA, 1, 1, "R4 slave");
      t_byte(8'h90, 1, 1, "R4 word");
      wp_pin = 1'b1; t_ackend(); wp_pin = 1'b0;
      wr_addr = 8'h90; t_byte(8'h01, 1, 0, "R4 wp sampled high");
      t_ackend();
      t_byte(8'h02, 1, 0, "R4 wp still latched");
      t_stop(0, 0, 0, "R4");

      // R4 WP low at the strobe, high later
      t_start();
      wp_pin = 1'b1;
      t_byte(8'hAA, 1, 1, "R4 slave b");
      t_byte(8'h90, 1, 1, "R4 word b");
      wp_pin = 1'b0; t_ackend(); wp_pin = 1'b1;
      t_byte(8'h03, 1, 1, "R4 late wp ignored");
      wp_pin = 1'b0;
      t_stop(0, 0, 0, "R4 b");

      // R6 permanent query, flag clear
      t_start();
      t_byte(8'h61, 1, 1, "R6 perm query clear");
      t_byte(8'h00, 0, 0, "R6 no data");
      t_stop(0, 0, 0, "R6");

      // R7 set reversible
      hv_a0 = 1'b1;
      t_start();
      t_byte(8'h62, 1, 1, "R7 set rev slave");
      t_byte(8'h00, 1, 1, "R7 dummy addr");
      t_ackend();
      t_byte(8'h00, 1, 1, "R7 dummy data");
      t_stop(0, 1, 0, "R7 set");
      chk(rev_flag, 1'b1, "R7 rev_flag set");
      chk(perm_flag, 1'b0, "R7 perm untouched");

      // R6 reversible query, flag set -> refuse
      t_start();
      t_byte(8'h63, 1, 0, "R6 rev query set");
      t_stop(0, 0, 0, "R6 rev");
      hv_a0 = 1'b0;

      // R8 qualifier missing at START -> permanent query
      t_start();
      hv_a0 = 1'b1;
      t_byte(8'h63, 1, 1, "R8 late hv gives perm query");
      t_stop(0, 0, 0, "R8 late");

      // R9 qualified, invalid select
      hv_a0 = 1'b1;
      t_start();
      t_byte(8'h6A, 1, 0, "R9 bad select");
      t_stop(0, 0, 0, "R9");
      hv_a0 = 1'b0;

      // R3 lower half blocked by reversible flag
      t_start();
      t_byte(8'hAA, 1, 1, "R3 slave");
      t_byte(8'h7F, 1, 1, "R3 word");
      t_ackend();
      wr_addr = 8'h7F; t_byte(8'h11, 1, 0, "R3 0x7F protected");
      wr_addr = 8'h80; t_byte(8'h22, 1, 1, "R3 0x80 writable");
      t_stop(0, 0, 0, "R3 prot");

      // R7 clear reversible
      hv_a0 = 1'b1;
      t_start();
      t_byte(8'h66, 1, 1, "R7 clr slave");
      t_byte(8'h00, 1, 1, "R7 clr addr");
      t_ackend();
      t_byte(8'h00, 1, 1, "R7 clr data");
      t_stop(0, 0, 1, "R7 clr");
      chk(rev_flag, 1'b0, "R7 rev_flag cleared");
      hv_a0 = 1'b0;

      // R11 WP blocks a permanent set
      t_start();
      t_byte(8'h64, 1, 1, "R11 slave");
      t_byte(8'h00, 1, 1, "R11 addr");
      wp_pin = 1'b1; t_ackend(); wp_pin = 1'b0;
      t_byte(8'h00, 1, 0, "R11 data refused");
      t_stop(0, 0, 0, "R11");
      chk(perm_flag, 1'b0, "R11 perm unchanged");

      // R12 repeated START cancels a complete command
      t_start();
      t_byte(8'h60, 1, 1, "R12 slave");
      t_byte(8'h00, 1, 1, "R12 addr");
      t_ackend();
      t_byte(8'h00, 1, 1, "R12 data");
      t_start();
      t_stop(0, 0, 0, "R12 cancelled");
      chk(perm_flag, 1'b0, "R12 perm unchanged");

      // R8 qualifier dropped before STOP -> permanent set
      hv_a0 = 1'b1;
      t_start();
      t_byte(8'h62, 1, 1, "R8 slave");
      t_byte(8'h00, 1, 1, "R8 addr");
      t_ackend();
      t_byte(8'h00, 1, 1, "R8 data");
      hv_a0 = 1'b0;
      t_stop(1, 0, 0, "R8 dropped");
      chk(perm_flag, 1'b1, "R8 perm set");
      chk(rev_flag,  1'b0, "R8 rev untouched");

      // R5/R10 after the permanent flag is set
      t_start();
      t_byte(8'h60, 1, 0, "R10 perm set refused");
      t_stop(0, 0, 0, "R10 a");
      hv_a0 = 1'b1;
      t_start();
      t_byte(8'h66, 1, 0, "R10 rev clear refused");
      t_byte(8'h00, 0, 0, "R10 skip");
      t_stop(0, 0, 0, "R10 b");
      t_start();
      t_byte(8'h63, 1, 1, "R6 rev query clear");
      t_stop(0, 0, 0, "R6 c");
      hv_a0 = 1'b0;
      t_start();
      t_byte(8'h61, 1, 0, "R6 perm query set");
      t_stop(0, 0, 0, "R6 d");
      t_start();
      t_byte(8'hAA, 1, 1, "R10 slave");
      t_byte(8'h00, 1, 1, "R10 word");
      t_ackend();
      wr_addr = 8'h00; t_byte(8'h33, 1, 0, "R5 perm protects low half");
      t_stop(0, 0, 0, "R10 mem");
      chk(perm_flag, 1'b1, "R10 perm sticky");

      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R13 leftover verdicts: actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule